// File: doc/BRIEF.md
# Barrel Thread Issue Scheduler

This block decides, on every clock, which one of a set of hardware threads may send an instruction into a shared pipeline. Each thread has two qualifying inputs. The active bit says that the thread exists and holds work. The ready bit drops while the thread is blocked on I/O. The scheduler hands out issue slots in rotating order. It enforces a spacing rule: a thread may issue only after its previous instruction has drained from the pipeline, which caps every thread at one slot per pipeline depth.

With four or fewer active threads, each one receives exactly one slot in four and the remaining slots stay empty. With more active threads, every thread receives at least one slot per rotation. When a thread stalls, the slot it would have used passes to another ready thread, so the threads still running go faster. The decision is registered. The issue flag and the thread index appear one cycle after the inputs that produced them.

Top module: `thread_issue_sched`

## Requirements
- R1: A synchronous active-high reset clears the issue flag, the thread index and all scheduling state. After reset, no issue occurs in any cycle that has no active thread.
- R2: An issue reported in cycle c+1 always names a thread whose active and ready bits were both 1 in cycle c. The outputs are registered, with one cycle of latency. At most one thread issues per cycle, and the index is the binary thread number.
- R3: A thread that issued in cycle c does not issue again before cycle c+PIPE_DEPTH (PIPE_DEPTH = 4).
- R4: With n ≤ 4 threads active and all of them ready, each thread issues exactly once every 4 cycles. The other 4−n slots carry no issue.
- R5: With n > 4 threads active and all of them ready, each thread issues exactly once every n cycles.
- R6: The search for the next issuer starts at the thread after the last one that issued. It moves up in index order, wraps from the highest thread to thread 0, and skips threads that are inactive, not ready, or still inside their spacing window.
- R7: In any cycle where some thread is active, ready and clear of its spacing window, an issue occurs. The slots that a stalled thread leaves go to the other threads, which may then exceed 1/n.
- R8: A thread that stays active and ready is never passed over for more than NUM_THREADS−1 consecutive cycles once it is eligible. Consecutive issues of that thread are therefore at most n+3 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| active_mask | input | NUM_THREADS | Bit t set: thread t takes part in scheduling |
| ready_mask | input | NUM_THREADS | Bit t set: thread t is not stalled on I/O |
| issue_valid | output | 1 | An instruction issues this cycle |
| issue_tid | output | clog2(NUM_THREADS) | Index of the issuing thread |

## Verification
A behavioural model checks the outputs every cycle while the block runs through several kinds of input. First, every active count from 1 to 8 with all threads ready. These runs tell the 1/4 spacing cap apart from plain 1/n rotation, and a shift in the window count exposes a wrong boundary between the two regimes. Second, a sparse, non-contiguous active set, which shows that inactive threads are skipped and the search wraps correctly. Third, a run with one thread permanently stalled, which shows whether its slots go to the others instead of becoming bubbles. Fourth, random stalls on every thread except one that stays ready; this run limits the gap between that thread's issues.

// File: rtl/sched_pkg.sv
package sched_pkg;
  // index width for a count of items, never below one bit
  function automatic int unsigned idx_width(input int unsigned count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/thread_cooldown.sv
module thread_cooldown #(
  parameter int unsigned PIPE_DEPTH = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic issued,
  output logic clear
);
  localparam int unsigned CW = sched_pkg::idx_width(PIPE_DEPTH);
  localparam logic [CW-1:0] RELOAD = CW'(PIPE_DEPTH - 1);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (issued) begin
      remain_q <= RELOAD;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign clear = (remain_q == '0);
endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
  parameter int unsigned NUM_REQ = 8
) (
  input  logic [NUM_REQ-1:0]                          req,
  input  logic [sched_pkg::idx_width(NUM_REQ)-1:0]    start,
  output logic                                        found,
  output logic [sched_pkg::idx_width(NUM_REQ)-1:0]    winner
);
  localparam int unsigned IW = sched_pkg::idx_width(NUM_REQ);

  always_comb begin
    found  = 1'b0;
    winner = '0;
    for (int off = 0; off < int'(NUM_REQ); off++) begin
      int cand;
      cand = int'(start) + off;
      if (cand >= int'(NUM_REQ)) cand = cand - int'(NUM_REQ);
      if (!found && req[cand]) begin
        found  = 1'b1;
        winner = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched #(
  parameter int unsigned NUM_THREADS = 8,
  parameter int unsigned PIPE_DEPTH  = 4
) (
  input  logic                                          clk,
  input  logic                                          rst,
  input  logic [NUM_THREADS-1:0]                        active_mask,
  input  logic [NUM_THREADS-1:0]                        ready_mask,
  output logic                                          issue_valid,
  output logic [sched_pkg::idx_width(NUM_THREADS)-1:0]  issue_tid
);
  localparam int unsigned TW = sched_pkg::idx_width(NUM_THREADS);
  localparam logic [TW-1:0] LAST_TID = TW'(NUM_THREADS - 1);

  logic [NUM_THREADS-1:0] spaced;
  logic [NUM_THREADS-1:0] eligible;
  logic [NUM_THREADS-1:0] grant_vec;
  logic                   pick_any;
  logic [TW-1:0]          pick_idx;
  logic [TW-1:0]          rot_q;

  assign eligible = active_mask & ready_mask & spaced;

  rr_picker #(.NUM_REQ(NUM_THREADS)) u_pick (
    .req    (eligible),
    .start  (rot_q),
    .found  (pick_any),
    .winner (pick_idx)
  );

  genvar t;
  generate
    for (t = 0; t < NUM_THREADS; t++) begin : g_thr
      assign grant_vec[t] = pick_any && (pick_idx == TW'(t));

      thread_cooldown #(.PIPE_DEPTH(PIPE_DEPTH)) u_cool (
        .clk    (clk),
        .rst    (rst),
        .issued (grant_vec[t]),
        .clear  (spaced[t])
      );

      // R3 checker: cycles since this thread last appeared on the outputs
      int unsigned since_q;
      always_ff @(posedge clk) begin
        if (rst) since_q <= PIPE_DEPTH;
        else if (issue_valid && issue_tid == TW'(t)) since_q <= 1;
        else if (since_q < PIPE_DEPTH) since_q <= since_q + 1;
      end
      a_r3_min_gap: assert property (@(posedge clk) disable iff (rst)
        (issue_valid && issue_tid == TW'(t)) |-> (since_q >= PIPE_DEPTH));

      // R8 checker: consecutive cycles eligible without being granted
      int unsigned pass_q;
      always_ff @(posedge clk) begin
        if (rst) pass_q <= 0;
        else if (eligible[t] && !grant_vec[t]) pass_q <= pass_q + 1;
        else pass_q <= 0;
      end
      a_r8_wait_bound: assert property (@(posedge clk) disable iff (rst)
        pass_q < NUM_THREADS);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rot_q       <= '0;
      issue_valid <= 1'b0;
      issue_tid   <= '0;
    end else begin
      issue_valid <= pick_any;
      issue_tid   <= pick_any ? pick_idx : '0;
      if (pick_any) rot_q <= (pick_idx == LAST_TID) ? '0 : pick_idx + 1'b1;
    end
  end

  a_r2_issue_source: assert property (@(posedge clk) disable iff (rst)
    issue_valid |->
      ((($past(active_mask & ready_mask)) >> issue_tid) & NUM_THREADS'(1)) != '0);

  a_r7_work_conserving: assert property (@(posedge clk) disable iff (rst)
    (|eligible) |=> issue_valid);

  a_r1_idle_without_threads: assert property (@(posedge clk) disable iff (rst)
    (active_mask == '0) |=> !issue_valid);
endmodule

// File: tb/test_thread_issue_sched.sv
module test_thread_issue_sched;
  localparam int N  = 8;
  localparam int PD = 4;
  localparam int W  = 840;

  logic         clk;
  logic         rst;
  logic [N-1:0] act;
  logic [N-1:0] rdy;
  logic         issue_valid;
  logic [2:0]   issue_tid;

  thread_issue_sched #(.NUM_THREADS(N), .PIPE_DEPTH(PD)) i_thread_issue_sched (
    .clk         (clk),
    .rst         (rst),
    .active_mask (act),
    .ready_mask  (rdy),
    .issue_valid (issue_valid),
    .issue_tid   (issue_tid)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int k      = 0;
  int ptr    = 0;
  int last_iss [N];
  int cnt [N];
  bit exp_known = 0;
  bit exp_v;
  int exp_t;
  bit gap_on = 0;
  int gap_lim = 0;
  int gap_last = 0;
  string tag = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic tick(input bit r, input logic [N-1:0] a, input logic [N-1:0] rd);
    bit found;
    int pick;
    if (exp_known) begin
      check(issue_valid === exp_v, tag, "issue_valid", int'(issue_valid), int'(exp_v));
      if (exp_v)
        check(int'(issue_tid) == exp_t, tag, "issue_tid", int'(issue_tid), exp_t);
      if (issue_valid === 1'b1) begin
        cnt[issue_tid]++;
        if (gap_on && issue_tid == 3'd3) begin
          check((k - gap_last) <= gap_lim, "R8", "gap of thread 3", k - gap_last, gap_lim);
          gap_last = k;
        end
      end
    end
    rst = r; act = a; rdy = rd;
    if (r) begin
      exp_v = 0; exp_t = 0; ptr = 0;
      for (int i = 0; i < N; i++) last_iss[i] = -1000;
    end else begin
      found = 0; pick = 0;
      for (int off = 0; off < N; off++) begin
        int c;
        c = (ptr + off) % N;
        if (!found && a[c] && rd[c] && (k - last_iss[c] >= PD)) begin
          found = 1; pick = c;
        end
      end
      exp_v = found; exp_t = pick;
      if (found) begin
        last_iss[pick] = k;
        ptr = (pick + 1) % N;
      end
    end
    exp_known = 1;
    k++;
    @(negedge clk);
  endtask

  task automatic clear_counts();
    for (int i = 0; i < N; i++) cnt[i] = 0;
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; act = '0; rdy = '0;
    @(negedge clk);
    tag = "R1";
    for (int i = 0; i < 3; i++) tick(1'b1, '0, '0);
    for (int i = 0; i < 5; i++) tick(1'b0, '0, 8'hFF);
    check(issue_valid === 1'b0 && issue_tid === 3'd0, "R1", "reset outputs",
          int'(issue_valid), 0);

    // active counts 1..8, all ready: share per window of W cycles
    for (int n = 1; n <= N; n++) begin
      logic [N-1:0] m;
      int expc;
      bit ok;
      int bad_t;
      m = N'((1 << n) - 1);
      tag = (n <= 4) ? "R4" : "R5";
      for (int i = 0; i < 16; i++) tick(1'b0, m, m);
      clear_counts();
      for (int i = 0; i < W; i++) tick(1'b0, m, m);
      expc = (n <= 4) ? W / 4 : W / n;
      ok = 1; bad_t = 0;
      for (int t = 0; t < N; t++)
        if (cnt[t] != ((t < n) ? expc : 0)) begin ok = 0; bad_t = t; end
      check(ok, tag, $sformatf("window share n=%0d thread %0d", n, bad_t),
            cnt[bad_t], (bad_t < n) ? expc : 0);
    end

    // sparse active set: skipping and wrap order
    tag = "R6";
    for (int i = 0; i < 60; i++) tick(1'b0, 8'b1010_0101, 8'hFF);
    for (int i = 0; i < 60; i++) tick(1'b0, 8'b1111_0110, 8'hFF);

    // one thread stalled: its slots go to the rest
    tag = "R7";
    for (int i = 0; i < 16; i++) tick(1'b0, 8'h3F, 8'h3E);
    clear_counts();
    for (int i = 0; i < W; i++) tick(1'b0, 8'h3F, 8'h3E);
    check(cnt[0] == 0, "R7", "stalled thread issues", cnt[0], 0);
    check(cnt[1] == W / 5, "R7", "thread 1 share with a stalled peer", cnt[1], W / 5);
    check(cnt[5] == W / 5, "R7", "thread 5 share with a stalled peer", cnt[5], W / 5);

    // random stalls, thread 3 always ready: bounded gap
    tag = "R8";
    for (int ph = 0; ph < 2; ph++) begin
      logic [N-1:0] m;
      m = (ph == 0) ? 8'hFF : 8'h3F;
      gap_lim = ((ph == 0) ? 8 : 6) + 3;
      for (int i = 0; i < 16; i++) tick(1'b0, m, m);
      gap_last = k; gap_on = 1;
      for (int i = 0; i < 2000; i++) begin
        logic [N-1:0] r;
        r = N'($urandom) | 8'h08;
        tick(1'b0, m, r);
      end
      gap_on = 0;
    end

    // idle again and reset mid-run
    tag = "R2";
    for (int i = 0; i < 30; i++) tick(1'b0, 8'hC3, N'($urandom));
    tag = "R1";
    tick(1'b1, 8'hFF, 8'hFF);
    tick(1'b0, '0, 8'hFF);
    tick(1'b0, '0, 8'hFF);
    check(issue_valid === 1'b0, "R1", "no issue without active threads",
          int'(issue_valid), 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule